// File: doc/BRIEF.md
# Fully Associative Read Cache with Selectable Victim Policy

This block is a small read-only cache with a single set. Any address may be held in any line. On every lookup the full request address is compared with the stored address of every valid line at the same time. A hit returns the stored byte on the next cycle. A miss raises a read request on a synchronous backing-memory port. It then waits for that memory to pulse its valid strobe, writes the returned byte into a line, and passes the byte back with the hit flag low.

When the cache is full, a 2-bit mode input picks the line to evict, at the moment of each fill. The four choices are least recently used, oldest fill, fewest hits, and pseudo-random. The bookkeeping for all four policies is updated on every access, whatever mode is selected. This means the mode can change at run time without losing history. The defaults give four lines of one byte each behind a 4-bit address. The address has no set-index bits and no offset bits, so all four address bits form the tag.

Top module: `fa_byte_cache`

## Requirements
- R1: After a synchronous reset every line is invalid, `rsp_valid` and `mem_rd` are low, `req_ready` is high, and the first request to any address misses.
- R2: A request accepted (`req_valid` with `req_ready` high) to an address held in a valid line produces, in the next cycle, `rsp_valid`=1, `rsp_hit`=1 and the stored byte on `rsp_data`. `req_ready` stays high, so hits may be issued back to back, and no memory read is raised.
- R3: An accepted request that misses drives `mem_rd`=1 with `mem_addr` equal to the request address from the next cycle. `req_ready` is low, and both outputs hold until a cycle in which `mem_valid` is sampled high. In the cycle after that one, `rsp_valid`=1, `rsp_hit`=0, `rsp_data` equals the `mem_data` sampled, `mem_rd`=0 and `req_ready`=1.
- R4: A fill goes to the lowest-numbered invalid line while any line is invalid. Only a full cache evicts, using the policy selected by `repl_mode` in the cycle of the fill.
- R5: `repl_mode`=0 (recency): the victim is the line whose last hit or fill is oldest.
- R6: `repl_mode`=1 (arrival order): the victim is the line filled earliest, regardless of later hits.
- R7: `repl_mode`=2 (frequency): the victim is the line with the fewest hits since its fill, and ties go to the lowest index. Each line's hit count is cleared by a fill and saturates at 2^HIT_W-1.
- R8: `repl_mode`=3 (random): the victim is the low log2(LINES) bits of an 8-bit shift register. The register is set to 0x01 on reset and on every other cycle shifts left, taking in the XOR of the bits selected by mask 0xB8 (bits 7, 5, 4, 3).
- R9: `mem_valid` outside a pending miss has no effect. A `req_valid` while `req_ready` is low is ignored and does not fetch or fill its address.
- R10: All policy bookkeeping is kept in every mode, so a change of `repl_mode` between accesses selects its victim from the full history since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Byte address of the lookup |
| req_ready | output | 1 | High when a request can be accepted |
| repl_mode | input | 2 | Victim policy: 0 recency, 1 arrival, 2 frequency, 3 random |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from the cache (valid with rsp_valid) |
| rsp_data | output | DATA_W | Returned byte (valid with rsp_valid) |
| mem_rd | output | 1 | Backing memory read request, held until served |
| mem_addr | output | ADDR_W | Backing memory address |
| mem_valid | input | 1 | Backing memory data strobe |
| mem_data | input | DATA_W | Backing memory data |

## Verification
The bench targets the eviction order under each policy. Examples are a line that was hit just before a miss, which a recency design that ignored hits would throw away, and a line hit repeatedly under the arrival policy, which must still be evicted first. Frequency ties must fall to the lowest index, and a design that took the highest index would later miss on an address the reference still holds. Stray memory strobes and requests issued while a miss is pending are injected; a design that took them would fill a wrong address or answer twice. Run-time policy switching and random victims driven by the specified shift register show whether history is kept in every mode, because a wrong victim turns a later hit into a miss.

// File: rtl/fac_pkg.sv
package fac_pkg;
  typedef enum logic [1:0] {
    REPL_LRU  = 2'd0,
    REPL_FIFO = 2'd1,
    REPL_LFU  = 2'd2,
    REPL_RAND = 2'd3
  } repl_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } fsm_e;
endpackage

// File: rtl/fac_lfsr.sv
module fac_lfsr #(
  parameter int             W     = 8,
  parameter logic [W-1:0]   TAPS  = 'hB8,
  parameter logic [W-1:0]   SEED  = 'h01,
  parameter int             OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
  end

  assign rnd_o = state_q[OUT_W-1:0];

  // the register must never lock up in the all-zero state
  assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

// File: rtl/fac_rank_order.sv
module fac_rank_order #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_o
);
  localparam logic [IDX_W-1:0] TOP_RANK = IDX_W'(N - 1);

  logic [IDX_W-1:0] rank_q [N];
  logic [N-1:0]     oldest_vec;
  logic [IDX_W-1:0] touched_rank;

  assign touched_rank = rank_q[touch_idx];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rank
      always_ff @(posedge clk) begin
        if (rst) begin
          rank_q[g] <= IDX_W'(g);
        end else if (touch_en) begin
          if (touch_idx == IDX_W'(g))
            rank_q[g] <= '0;
          else if (rank_q[g] < touched_rank)
            rank_q[g] <= rank_q[g] + 1'b1;
        end
      end
      assign oldest_vec[g] = (rank_q[g] == TOP_RANK);
    end
  endgenerate

  always_comb begin
    oldest_o = '0;
    for (int i = 0; i < N; i++)
      if (oldest_vec[i]) oldest_o = IDX_W'(i);
  end

  // ranks remain a permutation: exactly one line is the oldest (R5, R6)
  assert_oldest_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot(oldest_vec));
  // a line just touched can never be the next victim (R5, R6)
  assert_touched_young_R6: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> oldest_o != $past(touch_idx));
endmodule

// File: rtl/fac_line_store.sv
module fac_line_store #(
  parameter int N      = 4,
  parameter int IDX_W  = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [N-1:0]      match_o,
  output logic [N-1:0]      valid_o,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] tag_q  [N];
  logic [DATA_W-1:0] byte_q [N];

  // data storage without reset, single write port
  always_ff @(posedge clk) begin
    if (fill_en) byte_q[fill_idx] <= fill_data;
  end
  assign rd_data = byte_q[rd_idx];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst)
          valid_o[g] <= 1'b0;
        else if (fill_en && fill_idx == IDX_W'(g))
          valid_o[g] <= 1'b1;
      end
      always_ff @(posedge clk) begin
        if (fill_en && fill_idx == IDX_W'(g)) tag_q[g] <= fill_addr;
      end
      assign match_o[g] = valid_o[g] && (tag_q[g] == look_addr);
    end
  endgenerate

  // an address can live in at most one line (R2)
  assert_match_unique_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_o));
  // a filled line becomes valid (R4)
  assert_fill_valid_R4: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_o[$past(fill_idx)]);
endmodule

// File: rtl/fac_victim_sel.sv
module fac_victim_sel
  import fac_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int HIT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic [N-1:0]     valid_i,
  input  repl_e            mode_i,
  input  logic [IDX_W-1:0] lru_i,
  input  logic [IDX_W-1:0] fifo_i,
  input  logic [IDX_W-1:0] rnd_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [HIT_W-1:0] cnt_q [N];
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] lfu_idx;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst)
          cnt_q[g] <= '0;
        else if (fill_en && fill_idx == IDX_W'(g))
          cnt_q[g] <= '0;
        else if (hit_en && hit_idx == IDX_W'(g) && cnt_q[g] != '1)
          cnt_q[g] <= cnt_q[g] + 1'b1;
      end

      // a fresh line starts with no hits (R7)
      assert_cnt_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        (fill_en && fill_idx == IDX_W'(g)) |=> cnt_q[g] == '0);
      // a saturated count holds until the line is refilled (R7)
      assert_cnt_saturates_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q[g] == '1 && !(fill_en && fill_idx == IDX_W'(g))) |=> cnt_q[g] == '1);
    end
  endgenerate

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    lfu_idx = '0;
    for (int i = 1; i < N; i++)
      if (cnt_q[i] < cnt_q[lfu_idx]) lfu_idx = IDX_W'(i);
  end

  always_comb begin
    if (free_any) begin
      victim_o = free_idx;
    end else begin
      unique case (mode_i)
        REPL_LRU:  victim_o = lru_i;
        REPL_FIFO: victim_o = fifo_i;
        REPL_LFU:  victim_o = lfu_idx;
        default:   victim_o = rnd_i;
      endcase
    end
  end
endmodule

// File: rtl/fa_byte_cache.sv
module fa_byte_cache
  import fac_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 8,
  parameter int                LINES     = 4,
  parameter int                HIT_W     = 8,
  parameter int                LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic [1:0]        repl_mode,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  fsm_e              state_q;
  logic [LINES-1:0]  match_vec;
  logic [LINES-1:0]  valid_vec;
  logic              hit_any;
  logic [IDX_W-1:0]  hit_idx;
  logic              accept;
  logic              hit_en;
  logic              fill_en;
  logic              touch_en;
  logic [IDX_W-1:0]  touch_idx;
  logic [IDX_W-1:0]  victim;
  logic [IDX_W-1:0]  lru_old;
  logic [IDX_W-1:0]  fifo_old;
  logic [IDX_W-1:0]  rnd_idx;
  logic [DATA_W-1:0] line_byte;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit_any   = |match_vec;
  assign hit_en    = accept && hit_any;
  assign fill_en   = (state_q == ST_FETCH) && mem_valid;
  assign touch_en  = hit_en || fill_en;
  assign touch_idx = fill_en ? victim : hit_idx;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (match_vec[i]) hit_idx = IDX_W'(i);
  end

  fac_line_store #(
    .N(LINES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .look_addr(req_addr), .match_o(match_vec), .valid_o(valid_vec),
    .fill_en(fill_en), .fill_idx(victim), .fill_addr(mem_addr), .fill_data(mem_data),
    .rd_idx(hit_idx), .rd_data(line_byte)
  );

  fac_rank_order #(.N(LINES), .IDX_W(IDX_W)) u_recency (
    .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx), .oldest_o(lru_old)
  );

  fac_rank_order #(.N(LINES), .IDX_W(IDX_W)) u_arrival (
    .clk(clk), .rst(rst), .touch_en(fill_en), .touch_idx(victim), .oldest_o(fifo_old)
  );

  fac_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .OUT_W(IDX_W)) u_rnd (
    .clk(clk), .rst(rst), .rnd_o(rnd_idx)
  );

  fac_victim_sel #(.N(LINES), .IDX_W(IDX_W), .HIT_W(HIT_W)) u_victim (
    .clk(clk), .rst(rst),
    .fill_en(fill_en), .fill_idx(victim),
    .hit_en(hit_en), .hit_idx(hit_idx),
    .valid_i(valid_vec), .mode_i(repl_e'(repl_mode)),
    .lru_i(lru_old), .fifo_i(fifo_old), .rnd_i(rnd_idx),
    .victim_o(victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (hit_any) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b1;
              rsp_data  <= line_byte;
            end else begin
              state_q  <= ST_FETCH;
              mem_rd   <= 1'b1;
              mem_addr <= req_addr;
            end
          end
        end
        default: begin
          if (mem_valid) begin
            state_q   <= ST_IDLE;
            mem_rd    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_data  <= mem_data;
          end
        end
      endcase
    end
  end

  // a pending read holds its request and address until served (R3)
  assert_read_held_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_valid) |=> (mem_rd && $stable(mem_addr)));
  // accepted hit answers on the next cycle with the hit flag (R2)
  assert_hit_answer_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && hit_any) |=> (rsp_valid && rsp_hit && !mem_rd));
  // filling a cache with a free line grows the valid count by one (R4)
  assert_free_first_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !(&valid_vec)) |=> $countones(valid_vec) == $countones($past(valid_vec)) + 1);
  // no response is produced while a miss is outstanding (R9)
  assert_quiet_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_valid) |=> !rsp_valid);
endmodule

// File: tb/test_fa_byte_cache.sv
module test_fa_byte_cache;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NL = 4;
  localparam int HMAX = 255;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready;
  logic [1:0]    repl_mode = 2'd0;
  logic          rsp_valid;
  logic          rsp_hit;
  logic [DW-1:0] rsp_data;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic          mem_valid = 1'b0;
  logic [DW-1:0] mem_data = '0;

  always #5 clk = ~clk;

  fa_byte_cache i_fa_byte_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .repl_mode(repl_mode), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data)
  );

  int    n_checks = 0;
  int    n_err = 0;
  string cur = "R1";
  bit    finished = 1'b0;

  function automatic logic [DW-1:0] mem_byte(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit            m_valid [NL];
  logic [AW-1:0] m_tag   [NL];
  logic [DW-1:0] m_data  [NL];
  int            m_last  [NL];
  int            m_fill  [NL];
  int            m_hits  [NL];
  int            stamp;
  logic [7:0]    m_lfsr;
  bit            m_busy;
  bit            e_rsp_valid, e_hit, e_mem_rd;
  logic [DW-1:0] e_data;
  logic [AW-1:0] e_mem_addr;
  int            mk, mv;

  function automatic int pick_victim(input logic [1:0] pol);
    int best;
    for (int i = 0; i < NL; i++) if (!m_valid[i]) return i;
    best = 0;
    case (pol)
      2'd0: for (int i = 1; i < NL; i++) if (m_last[i] < m_last[best]) best = i;
      2'd1: for (int i = 1; i < NL; i++) if (m_fill[i] < m_fill[best]) best = i;
      2'd2: for (int i = 1; i < NL; i++) if (m_hits[i] < m_hits[best]) best = i;
      default: best = int'(m_lfsr) % NL;
    endcase
    return best;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) begin
        m_valid[i] = 1'b0; m_last[i] = 0; m_fill[i] = 0; m_hits[i] = 0;
      end
      stamp = 0; m_lfsr = 8'h01; m_busy = 1'b0;
      e_rsp_valid = 1'b0; e_mem_rd = 1'b0; e_hit = 1'b0; e_data = '0; e_mem_addr = '0;
    end else begin
      e_rsp_valid = 1'b0;
      if (!m_busy) begin
        if (req_valid) begin
          mk = -1;
          for (int i = 0; i < NL; i++) if (m_valid[i] && m_tag[i] == req_addr) mk = i;
          if (mk >= 0) begin
            e_rsp_valid = 1'b1; e_hit = 1'b1; e_data = m_data[mk];
            stamp++; m_last[mk] = stamp;
            if (m_hits[mk] < HMAX) m_hits[mk]++;
          end else begin
            m_busy = 1'b1; e_mem_rd = 1'b1; e_mem_addr = req_addr;
          end
        end
      end else if (mem_valid) begin
        mv = pick_victim(repl_mode);
        m_valid[mv] = 1'b1; m_tag[mv] = e_mem_addr; m_data[mv] = mem_data;
        stamp++; m_last[mv] = stamp; m_fill[mv] = stamp; m_hits[mv] = 0;
        e_rsp_valid = 1'b1; e_hit = 1'b0; e_data = mem_data;
        e_mem_rd = 1'b0; m_busy = 1'b0;
      end
      m_lfsr = {m_lfsr[6:0], ^(m_lfsr & 8'hB8)};
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(req_ready === !m_busy, "req_ready", int'(req_ready), int'(!m_busy));
      chk(mem_rd === e_mem_rd, "mem_rd", int'(mem_rd), int'(e_mem_rd));
      if (e_mem_rd) chk(mem_addr === e_mem_addr, "mem_addr (R3)", int'(mem_addr), int'(e_mem_addr));
      chk(rsp_valid === e_rsp_valid, "rsp_valid", int'(rsp_valid), int'(e_rsp_valid));
      if (e_rsp_valid) begin
        chk(rsp_hit === e_hit, "rsp_hit", int'(rsp_hit), int'(e_hit));
        chk(rsp_data === e_data, "rsp_data", int'(rsp_data), int'(e_data));
      end
    end
  end

  // ---------------- backing memory ----------------
  int mem_lat = 1;
  int wait_cnt = 0;
  bit spur = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      mem_valid = 1'b0;
      if (mem_rd) begin
        wait_cnt++;
        if (wait_cnt > mem_lat) begin
          mem_valid = 1'b1; mem_data = mem_byte(mem_addr); wait_cnt = 0;
        end
      end else begin
        wait_cnt = 0;
        if (spur) begin
          mem_valid = 1'b1; mem_data = 8'hEE; spur = 1'b0;
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic access(input logic [AW-1:0] a, output logic hit_o);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    hit_o = rsp_hit;
  endtask

  task automatic expect_hit(input logic [AW-1:0] a, input bit exp, input string tag);
    logic h;
    access(a, h);
    n_checks++;
    if (h !== exp) begin
      n_err++;
      $display("FAIL %s hit flag for addr %0h: actual %0b expected %0b", tag, a, h, exp);
    end
  endtask

  task automatic fill_four();
    for (int i = 1; i <= 4; i++) expect_hit(AW'(i), 1'b0, "R4");
  endtask

  initial begin
    logic h;
    int   nv;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(rsp_valid === 1'b0, "reset rsp_valid", int'(rsp_valid), 0);
    chk(mem_rd === 1'b0, "reset mem_rd", int'(mem_rd), 0);
    chk(req_ready === 1'b1, "reset req_ready", int'(req_ready), 1);
    expect_hit(4'h9, 1'b0, "R1");

    // R5 recency
    do_reset(); cur = "R5"; repl_mode = 2'd0;
    fill_four();
    expect_hit(4'h1, 1'b1, "R2");
    expect_hit(4'h5, 1'b0, "R5");
    expect_hit(4'h1, 1'b1, "R5");
    expect_hit(4'h2, 1'b0, "R5");
    expect_hit(4'h3, 1'b0, "R5");
    expect_hit(4'h5, 1'b1, "R5");

    // R6 arrival order
    do_reset(); cur = "R6"; repl_mode = 2'd1;
    fill_four();
    repeat (3) expect_hit(4'h1, 1'b1, "R6");
    expect_hit(4'h5, 1'b0, "R6");
    expect_hit(4'h2, 1'b1, "R6");
    expect_hit(4'h1, 1'b0, "R6");
    expect_hit(4'h2, 1'b0, "R6");

    // R7 frequency
    do_reset(); cur = "R7"; repl_mode = 2'd2; mem_lat = 2;
    fill_four();
    repeat (3) expect_hit(4'h1, 1'b1, "R7");
    expect_hit(4'h2, 1'b1, "R7");
    repeat (2) expect_hit(4'h4, 1'b1, "R7");
    expect_hit(4'h5, 1'b0, "R7");
    expect_hit(4'h3, 1'b0, "R7");
    expect_hit(4'h5, 1'b0, "R7");
    expect_hit(4'h1, 1'b1, "R7");
    expect_hit(4'h4, 1'b1, "R7");
    // ties fall to the lowest index
    do_reset(); mem_lat = 0;
    fill_four();
    expect_hit(4'h6, 1'b0, "R7");
    expect_hit(4'h2, 1'b1, "R7");
    expect_hit(4'h1, 1'b0, "R7");
    expect_hit(4'h6, 1'b0, "R7");

    // R8 random
    do_reset(); cur = "R8"; repl_mode = 2'd3; mem_lat = 1;
    fill_four();
    for (int i = 0; i < 60; i++) access(AW'($urandom_range(0, 9)), h);

    // R9 stray strobes and requests while busy
    do_reset(); cur = "R9"; repl_mode = 2'd0; mem_lat = 3;
    spur = 1'b1; repeat (3) @(negedge clk);
    expect_hit(4'h2, 1'b0, "R9");
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = 4'h7;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 4'hC;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
    expect_hit(4'hC, 1'b0, "R9");
    expect_hit(4'h7, 1'b1, "R9");

    // R2 back-to-back hits
    do_reset(); cur = "R2"; mem_lat = 0;
    fill_four();
    @(negedge clk);
    nv = 0;
    for (int i = 1; i <= 4; i++) begin
      req_valid = 1'b1; req_addr = AW'(i);
      @(negedge clk);
      if (rsp_valid && rsp_hit) nv++;
    end
    req_valid = 1'b0;
    chk(nv == 4, "back-to-back hit responses", nv, 4);

    // R10 run-time policy switching under mixed traffic
    do_reset(); cur = "R10";
    for (int i = 0; i < 400; i++) begin
      repl_mode = 2'($urandom_range(0, 3));
      mem_lat = $urandom_range(0, 3);
      if ($urandom_range(0, 9) == 0 && req_ready) spur = 1'b1;
      access(AW'($urandom_range(0, 7)), h);
    end

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_err++;
      $display("FAIL %s watchdog expired: actual running expected done", cur);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule